// File: doc/BRIEF.md
# Reverse-Carry Auxiliary Address Generator

This block produces data-memory operand addresses for a DSP-style datapath. It holds a bank of eight 16-bit auxiliary registers. A 3-bit pointer selects one register as the current one. The selected register always drives the address output.

When the access strobe is high, the current value is used as the address for that cycle. On the same clock edge, the register is rewritten according to the requested mode. The modes are:

- keep the value
- step it by one up or down
- add or subtract the index held in register 0
- add or subtract that index with the carry running from the most significant bit toward bit 0

The last pair of modes walks the bit-reversed address orders that radix-2 FFT stages need. The memory, the arithmetic unit and direct page addressing are outside this block.

Software or a sequencer loads any register with a full 16-bit value through the load port. It moves the pointer through the pointer-load port.

Top module: `bitrev_agu`

## Requirements
- R1: After reset, all eight registers and the pointer are zero, so `addr_o` reads 0.
- R2: `addr_o` always equals the register selected by the pointer. An access therefore presents the value from before the update (post-modify), and the update is visible from the cycle after the clock edge.
- R3: Mode codes on `mode_i`: 0 and 7 keep the register unchanged. 1 adds 1 and 2 subtracts 1, both modulo 2^16.
- R4: Mode 3 adds register 0 to the current register and mode 4 subtracts register 0 from it, both modulo 2^16. When the pointer is 0, the old value of register 0 is used as the index.
- R5: Mode 5 adds register 0 with the carry travelling from bit 15 toward bit 0 over all 16 bits. A carry out of bit 0 is dropped. With register 0 = 4 and a start of 60h, eight accesses present 60h, 64h, 62h, 66h, 61h, 65h, 63h, 67h.
- R6: Mode 6 subtracts register 0 with the borrow travelling from bit 15 toward bit 0; a borrow out of bit 0 is dropped. Starting at 67h with index 4, it retraces the R5 sequence backward.
- R7: A load writes `ld_val_i` into register `ld_sel_i` at the clock edge. If it targets the register being accessed in the same cycle, the load value wins.
- R8: A load into a register other than the accessed one and the access update both take effect in the same cycle.
- R9: A pointer load takes effect at the clock edge. An access in the same cycle still uses and updates the old pointer's register.
- R10: While `acc_i` is low, no register changes for any value of `mode_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_i | input | 1 | Access strobe: commit the update of the current register |
| mode_i | input | 3 | Update mode code (see R3 to R6) |
| ld_en_i | input | 1 | Register load enable |
| ld_sel_i | input | 3 | Register to load |
| ld_val_i | input | 16 | Load value |
| ptr_ld_i | input | 1 | Pointer load enable |
| ptr_val_i | input | 3 | New pointer value |
| addr_o | output | 16 | Current register value, used as the operand address |

## Verification
The hardest situations to reach from the ports are collisions within a single cycle. These are a load, a pointer move and an access all landing together, and an indexed access made on register 0 itself, which serves as its own index. Reverse-carry borrows that cross all 16 bits are also hard to reach.

Random stimulus with a fixed seed fires all three controls independently and often. It keeps the pointer at 0 a large share of the time and loads wide random values. This drives carries and borrows through the top bits. Directed runs reproduce the 60h-to-67h bit-reversed walk in both directions, plus the explicit load-versus-access tie.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned NUM_REGS = 8;
  localparam int unsigned PTR_W    = $clog2(NUM_REGS);
  localparam int unsigned MODE_W   = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_KEEP    = 3'd0,
    MODE_INC     = 3'd1,
    MODE_DEC     = 3'd2,
    MODE_ADD_IDX = 3'd3,
    MODE_SUB_IDX = 3'd4,
    MODE_ADD_RC  = 3'd5,
    MODE_SUB_RC  = 3'd6,
    MODE_KEEP2   = 3'd7
  } agu_mode_e;
endpackage

// File: rtl/agu_rc_unit.sv
// Reverse-carry add/sub: operate in the bit-reversed domain, then reverse back.
module agu_rc_unit #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] y_o
);
  logic [W-1:0] a_rev, b_rev, s_rev;

  for (genvar i = 0; i < W; i++) begin : g_rev_in
    assign a_rev[i] = a_i[W-1-i];
    assign b_rev[i] = b_i[W-1-i];
  end

  always_comb begin
    if (sub_i) s_rev = a_rev - b_rev;
    else       s_rev = a_rev + b_rev;
  end

  for (genvar i = 0; i < W; i++) begin : g_rev_out
    assign y_o[i] = s_rev[W-1-i];
  end
endmodule

// File: rtl/agu_step_unit.sv
module agu_step_unit
  import agu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0]      cur_i,
  input  logic [W-1:0]      idx_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [W-1:0]      nxt_o
);
  logic [W-1:0] rc_res;
  logic         rc_sub;

  assign rc_sub = (agu_mode_e'(mode_i) == MODE_SUB_RC);

  agu_rc_unit #(.W(W)) u_rc (
    .a_i  (cur_i),
    .b_i  (idx_i),
    .sub_i(rc_sub),
    .y_o  (rc_res)
  );

  always_comb begin
    unique case (agu_mode_e'(mode_i))
      MODE_INC:     nxt_o = cur_i + W'(1);
      MODE_DEC:     nxt_o = cur_i - W'(1);
      MODE_ADD_IDX: nxt_o = cur_i + idx_i;
      MODE_SUB_IDX: nxt_o = cur_i - idx_i;
      MODE_ADD_RC,
      MODE_SUB_RC:  nxt_o = rc_res;
      default:      nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/agu_reg_bank.sv
module agu_reg_bank
  import agu_pkg::*;
#(
  parameter int unsigned W = DATA_W,
  parameter int unsigned N = NUM_REGS,
  localparam int unsigned SW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_en_i,
  input  logic [SW-1:0] upd_sel_i,
  input  logic [W-1:0]  upd_val_i,
  input  logic          ld_en_i,
  input  logic [SW-1:0] ld_sel_i,
  input  logic [W-1:0]  ld_val_i,
  input  logic [SW-1:0] rd_sel_i,
  output logic [W-1:0]  rd_val_o,
  output logic [W-1:0]  idx_o
);
  logic [W-1:0] regs_q [N];

  for (genvar r = 0; r < N; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    regs_q[r] <= '0;
      else if (ld_en_i && ld_sel_i == SW'(r))         regs_q[r] <= ld_val_i;  // load wins
      else if (upd_en_i && upd_sel_i == SW'(r))       regs_q[r] <= upd_val_i;
    end
  end

  assign rd_val_o = regs_q[rd_sel_i];
  assign idx_o    = regs_q[0];
endmodule

// File: rtl/bitrev_agu.sv
module bitrev_agu
  import agu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              ld_en_i,
  input  logic [PTR_W-1:0]  ld_sel_i,
  input  logic [DATA_W-1:0] ld_val_i,
  input  logic              ptr_ld_i,
  input  logic [PTR_W-1:0]  ptr_val_i,
  output logic [DATA_W-1:0] addr_o
);
  logic [PTR_W-1:0]  ptr_q;
  logic [DATA_W-1:0] cur_val, idx_val, nxt_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ptr_q <= '0;
    else if (ptr_ld_i) ptr_q <= ptr_val_i;
  end

  agu_reg_bank #(.W(DATA_W), .N(NUM_REGS)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_en_i (acc_i),
    .upd_sel_i(ptr_q),
    .upd_val_i(nxt_val),
    .ld_en_i  (ld_en_i),
    .ld_sel_i (ld_sel_i),
    .ld_val_i (ld_val_i),
    .rd_sel_i (ptr_q),
    .rd_val_o (cur_val),
    .idx_o    (idx_val)
  );

  agu_step_unit #(.W(DATA_W)) u_step (
    .cur_i (cur_val),
    .idx_i (idx_val),
    .mode_i(mode_i),
    .nxt_o (nxt_val)
  );

  assign addr_o = cur_val;
endmodule

// File: rtl/bitrev_agu_chk.sv
module bitrev_agu_chk
  import agu_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_i,
  input logic [MODE_W-1:0] mode_i,
  input logic              ld_en_i,
  input logic [PTR_W-1:0]  ld_sel_i,
  input logic [DATA_W-1:0] ld_val_i,
  input logic              ptr_ld_i,
  input logic [PTR_W-1:0]  ptr_val_i,
  input logic [DATA_W-1:0] addr_o,
  input logic [PTR_W-1:0]  ptr_q
);
  logic quiet;
  assign quiet = !ld_en_i && !ptr_ld_i;

  // R3
  inc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && mode_i == 3'd1 && quiet) |=> addr_o == DATA_W'($past(addr_o) + 1'b1));

  // R3
  dec_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && mode_i == 3'd2 && quiet) |=> addr_o == DATA_W'($past(addr_o) - 1'b1));

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_i && quiet) |=> $stable(addr_o));

  // R7
  load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_en_i && !ptr_ld_i && ld_sel_i == ptr_q) |=> addr_o == $past(ld_val_i));

  // R9
  ptr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_ld_i |=> ptr_q == $past(ptr_val_i));
endmodule

bind bitrev_agu bitrev_agu_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .acc_i    (acc_i),
  .mode_i   (mode_i),
  .ld_en_i  (ld_en_i),
  .ld_sel_i (ld_sel_i),
  .ld_val_i (ld_val_i),
  .ptr_ld_i (ptr_ld_i),
  .ptr_val_i(ptr_val_i),
  .addr_o   (addr_o),
  .ptr_q    (ptr_q)
);

// File: tb/bitrev_agu_tb.sv
module bitrev_agu_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        acc_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic        ld_en_i = 1'b0;
  logic [2:0]  ld_sel_i = '0;
  logic [15:0] ld_val_i = '0;
  logic        ptr_ld_i = 1'b0;
  logic [2:0]  ptr_val_i = '0;
  logic [15:0] addr_o;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;

  logic [15:0] m_reg [8];
  logic [2:0]  m_ptr;
  string       tag;

  bitrev_agu u_dut (.*);

  always #5ns clk_i = ~clk_i;

  // Bit-serial reverse-direction carry/borrow, bit 15 down to bit 0.
  function automatic logic [15:0] rc_op(input logic [15:0] a, input logic [15:0] b, input bit sub);
    logic [15:0] y;
    logic c;
    c = 1'b0;
    for (int i = 15; i >= 0; i--) begin
      y[i] = a[i] ^ b[i] ^ c;
      if (sub) c = (~a[i] & b[i]) | (~(a[i] ^ b[i]) & c);
      else     c = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
    end
    return y;
  endfunction

  function automatic logic [15:0] model_next(input logic [15:0] cur, input logic [15:0] idx,
                                             input logic [2:0] md);
    case (md)
      3'd1: return cur + 16'd1;
      3'd2: return cur - 16'd1;
      3'd3: return cur + idx;
      3'd4: return cur - idx;
      3'd5: return rc_op(cur, idx, 1'b0);
      3'd6: return rc_op(cur, idx, 1'b1);
      default: return cur;
    endcase
  endfunction

  function automatic string mode_tag(input logic [2:0] md);
    case (md)
      3'd3, 3'd4: return "R4";
      3'd5: return "R5";
      3'd6: return "R6";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    n_chk++;
    if (addr_o !== exp) begin
      n_bad++;
      $display("FAIL %s: addr_o=%h expected=%h", req, addr_o, exp);
    end
  endtask

  // Drive one cycle (called at negedge), update model, return at next negedge.
  task automatic cycle(input bit acc, input logic [2:0] md, input bit ld, input logic [2:0] ls,
                       input logic [15:0] lv, input bit pl, input logic [2:0] pv);
    logic [15:0] nv;
    logic [2:0]  op;
    acc_i = acc; mode_i = md; ld_en_i = ld; ld_sel_i = ls; ld_val_i = lv;
    ptr_ld_i = pl; ptr_val_i = pv;
    #1ns check("R2", m_reg[m_ptr]);
    nv = model_next(m_reg[m_ptr], m_reg[0], md);
    op = m_ptr;
    if (acc) m_reg[op] = nv;
    if (ld)  m_reg[ls] = lv;
    if (pl)  m_ptr = pv;
    tag = ld ? (acc && ls == op ? "R7" : "R8") : (pl ? "R9" : (acc ? mode_tag(md) : "R10"));
    @(posedge clk_i);
    @(negedge clk_i);
    acc_i = 1'b0; ld_en_i = 1'b0; ptr_ld_i = 1'b0;
    #1ns check(tag, m_reg[m_ptr]);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    m_ptr = '0;
    repeat (3) @(negedge clk_i);
    check("R1", 16'h0000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: every register reads zero after reset
    for (int r = 0; r < 8; r++) cycle(0, 3'd0, 0, 3'd0, 16'h0, 1, 3'(r));

    // R5: bit-reversed walk 60h..67h with index 4
    cycle(0, 3'd0, 1, 3'd0, 16'h0004, 0, 3'd0);
    cycle(0, 3'd0, 1, 3'd1, 16'h0060, 1, 3'd1);
    begin
      logic [15:0] exp_seq [8] = '{16'h60, 16'h64, 16'h62, 16'h66, 16'h61, 16'h65, 16'h63, 16'h67};
      for (int k = 0; k < 8; k++) begin
        #1ns check("R5", exp_seq[k]);
        cycle(1, 3'd5, 0, 3'd0, 16'h0, 0, 3'd0);
      end
      // R6: retrace backward from 67h
      cycle(0, 3'd0, 1, 3'd1, 16'h0067, 0, 3'd0);
      for (int k = 7; k >= 0; k--) begin
        #1ns check("R6", exp_seq[k]);
        cycle(1, 3'd6, 0, 3'd0, 16'h0, 0, 3'd0);
      end
    end

    // R7: load and access on same register, load wins
    cycle(1, 3'd1, 1, 3'd1, 16'h0695, 0, 3'd0);
    check("R7", 16'h0695);
    // R10: no access, no change
    cycle(0, 3'd1, 0, 3'd0, 16'h0, 0, 3'd0);
    check("R10", 16'h0695);
    // R9: pointer move with access updates old register
    cycle(1, 3'd2, 0, 3'd0, 16'h0, 1, 3'd0);
    cycle(0, 3'd0, 0, 3'd0, 16'h0, 1, 3'd1);
    check("R9", 16'h0694);
    // R4: index modes on register 0 itself and with wrap
    cycle(0, 3'd0, 1, 3'd0, 16'h8001, 1, 3'd0);
    cycle(1, 3'd3, 0, 3'd0, 16'h0, 0, 3'd0);
    check("R4", 16'h0002);

    // Random mix, fixed seed
    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] pv;
      pv = ($urandom_range(0, 3) == 0) ? 3'd0 : 3'($urandom);
      cycle($urandom_range(0, 2) != 0, 3'($urandom), $urandom_range(0, 3) == 0, 3'($urandom),
            16'($urandom), $urandom_range(0, 4) == 0, pv);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1ms;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule